// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block sits next to a simple instruction fetch unit and lets a section of code repeat without any branch instruction. Software loads three registers through a narrow write port: the address of the first instruction in the section, the address of the last one, and a repeat count. Writing the count also arms repeat mode. The loop starts running on the very next fetch.

While repeat mode is armed, the block compares every valid fetch address with the stored last address. If more passes remain, it raises a redirect in that same cycle, pointing at the stored first address, and the counter steps down by one. On the final pass it lets fetch fall through in sequence, clears the counter to zero and disarms. The count can come from a short immediate, which is zero-extended, or from a full register value. Counts of 256 and above need the register source.

Top module: `zol_sequencer`

## Requirements
- R1: A synchronous active-high `rst` clears the start address, end address and counter to 0 and drops `loopActive` by the next clock edge.
- R2: A write with `regWrSel` = 0 stores `regWrData` as the section start address, and a write with `regWrSel` = 1 stores it as the section end address. The start address is later visible as `redirectTarget`.
- R3: A write with `regWrSel` = 2 loads the counter from `regWrData[7:0]`, zero-extended to 12 bits, and sets `loopActive`. Both take effect at the clock edge of the write.
- R4: A write with `regWrSel` = 3 loads the counter from `regWrData[11:0]` and sets `loopActive` at the clock edge of the write.
- R5: When `loopActive` is high, `fetchValid` is high, `fetchAddr` equals the end address and the counter is above 1, `redirectValid` is high in that same cycle with `redirectTarget` equal to the start address, and the counter is one lower after the edge.
- R6: When the end address is fetched while active with the counter at 0 or 1, `redirectValid` stays low. After the edge the counter is 0 and `loopActive` is low.
- R7: A sequential fetch stream that starts at the start address runs the section exactly N times for a loaded count N of 1 or more, and exactly once for a count of 0. This holds up to the 12-bit maximum of 4095.
- R8: A fetch of the end address while `loopActive` is low gives no redirect and leaves the counter and the active flag unchanged.
- R9: A register write in the same cycle as an end-address fetch takes priority. No redirect is given in that cycle, and the write alone decides the next counter value.
- R10: An end-address match with `fetchValid` low has no effect on the redirect, the counter or the active flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWrEn | input | 1 | Register write strobe |
| regWrSel | input | 2 | Write target: 0 start, 1 end, 2 count from immediate, 3 count from register |
| regWrData | input | 32 | Write data |
| fetchValid | input | 1 | Fetch address is valid this cycle |
| fetchAddr | input | 32 | Address being fetched |
| redirectValid | output | 1 | Next fetch must go to redirectTarget |
| redirectTarget | output | 32 | Section start address |
| loopActive | output | 1 | Repeat mode armed |
| repeatCount | output | 12 | Current counter value |

## Verification
`redirectValid` and `redirectTarget` are combinational from the fetch address. They are due in the same cycle as the fetch. The bench drives inputs just after a rising edge and samples them at the falling edge of that cycle. Counter and active-flag updates appear one edge after the write or the end-address fetch that causes them, so those are read just after the next rising edge. A fetch model in the bench steers its program counter from the sampled redirect. A scoreboard queue holds the expected redirect decision for every end-address fetch of each pass.

// File: rtl/zol_pkg.sv
package zol_pkg;

  typedef enum logic [1:0] {
    SEL_START   = 2'd0,
    SEL_END     = 2'd1,
    SEL_CNT_IMM = 2'd2,
    SEL_CNT_REG = 2'd3
  } regSel_e;

  typedef struct packed {
    logic ldStart;
    logic ldEnd;
    logic ldCount;
    logic cntFromImm;
    logic decCount;
    logic clrCount;
  } loopStrobe_t;

endpackage

// File: rtl/zol_ctrl.sv
module zol_ctrl
  import zol_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        regWrEn,
  input  logic [1:0]  regWrSel,
  input  logic        fetchValid,
  input  logic        endHit,
  input  logic        countAboveOne,
  output loopStrobe_t strb,
  output logic        loopActive,
  output logic        redirectValid
);

  logic endEvent;
  logic wrStart;
  logic wrEnd;
  logic wrCntImm;
  logic wrCntReg;

  always_comb begin
    wrStart  = regWrEn && (regSel_e'(regWrSel) == SEL_START);
    wrEnd    = regWrEn && (regSel_e'(regWrSel) == SEL_END);
    wrCntImm = regWrEn && (regSel_e'(regWrSel) == SEL_CNT_IMM);
    wrCntReg = regWrEn && (regSel_e'(regWrSel) == SEL_CNT_REG);
  end

  // any register write suppresses loop-end handling in that cycle
  assign endEvent      = loopActive && fetchValid && endHit && !regWrEn;
  assign redirectValid = endEvent && countAboveOne;

  always_comb begin
    strb            = '0;
    strb.ldStart    = wrStart;
    strb.ldEnd      = wrEnd;
    strb.ldCount    = wrCntImm || wrCntReg;
    strb.cntFromImm = wrCntImm;
    strb.decCount   = redirectValid;
    strb.clrCount   = endEvent && !countAboveOne;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loopActive <= 1'b0;
    end else if (strb.ldCount) begin
      loopActive <= 1'b1;
    end else if (strb.clrCount) begin
      loopActive <= 1'b0;
    end
  end

  // R5
  redirect_needs_active_chk: assert property (@(posedge clk) disable iff (rst)
    redirectValid |-> (loopActive && fetchValid));

  // R3
  count_write_arms_chk: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regWrSel[1]) |=> loopActive);

  // R9
  write_blocks_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    regWrEn |-> !redirectValid);

endmodule

// File: rtl/zol_dp.sv
module zol_dp
  import zol_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  loopStrobe_t       strb,
  input  logic [ADDR_W-1:0] regWrData,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              endHit,
  output logic              countAboveOne,
  output logic [ADDR_W-1:0] startAddr,
  output logic [CNT_W-1:0]  repeatCount
);

  localparam int PAD_W = CNT_W - IMM_W;

  logic [ADDR_W-1:0] endAddr;
  logic [CNT_W-1:0]  immCount;
  logic [CNT_W-1:0]  regCount;
  logic [CNT_W-1:0]  loadValue;

  generate
    if (PAD_W > 0) begin : g_padImm
      assign immCount = {{PAD_W{1'b0}}, regWrData[IMM_W-1:0]};
    end else begin : g_fullImm
      assign immCount = regWrData[CNT_W-1:0];
    end
  endgenerate

  assign regCount  = regWrData[CNT_W-1:0];
  assign loadValue = strb.cntFromImm ? immCount : regCount;

  always_ff @(posedge clk) begin
    if (rst) begin
      startAddr <= '0;
      endAddr   <= '0;
    end else begin
      if (strb.ldStart) startAddr <= regWrData;
      if (strb.ldEnd)   endAddr   <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      repeatCount <= '0;
    end else if (strb.ldCount) begin
      repeatCount <= loadValue;
    end else if (strb.decCount) begin
      repeatCount <= repeatCount - 1'b1;
    end else if (strb.clrCount) begin
      repeatCount <= '0;
    end
  end

  assign endHit        = (fetchAddr == endAddr);
  assign countAboveOne = (repeatCount > CNT_W'(1));

  // R5
  decrement_step_chk: assert property (@(posedge clk) disable iff (rst)
    strb.decCount |=> (repeatCount == $past(repeatCount) - 1'b1));

  // R6
  final_pass_zero_chk: assert property (@(posedge clk) disable iff (rst)
    strb.clrCount |=> (repeatCount == '0));

endmodule

// File: rtl/zol_sequencer.sv
module zol_sequencer
  import zol_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [1:0]        regWrSel,
  input  logic [ADDR_W-1:0] regWrData,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              redirectValid,
  output logic [ADDR_W-1:0] redirectTarget,
  output logic              loopActive,
  output logic [CNT_W-1:0]  repeatCount
);

  loopStrobe_t strb;
  logic endHit;
  logic countAboveOne;

  zol_ctrl i_ctrl (
    .clk           (clk),
    .rst           (rst),
    .regWrEn       (regWrEn),
    .regWrSel      (regWrSel),
    .fetchValid    (fetchValid),
    .endHit        (endHit),
    .countAboveOne (countAboveOne),
    .strb          (strb),
    .loopActive    (loopActive),
    .redirectValid (redirectValid)
  );

  zol_dp #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .IMM_W  (IMM_W)
  ) i_dp (
    .clk           (clk),
    .rst           (rst),
    .strb          (strb),
    .regWrData     (regWrData),
    .fetchAddr     (fetchAddr),
    .endHit        (endHit),
    .countAboveOne (countAboveOne),
    .startAddr     (redirectTarget),
    .repeatCount   (repeatCount)
  );

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (repeatCount == '0 && !loopActive && redirectTarget == '0));

  // R8
  idle_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
    (!loopActive && !regWrEn) |=> (!loopActive && $stable(repeatCount)));

  // R10
  invalid_fetch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fetchValid && !regWrEn) |=> ($stable(repeatCount) && $stable(loopActive)));

endmodule

// File: tb/test_zol_sequencer.sv
module test_zol_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 12;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              regWrEn = 1'b0;
  logic [1:0]        regWrSel = '0;
  logic [ADDR_W-1:0] regWrData = '0;
  logic              fetchValid = 1'b0;
  logic [ADDR_W-1:0] fetchAddr = '0;
  logic              redirectValid;
  logic [ADDR_W-1:0] redirectTarget;
  logic              loopActive;
  logic [CNT_W-1:0]  repeatCount;

  int compared = 0;
  int mismatched = 0;
  bit armed = 1'b0;
  logic [ADDR_W-1:0] curStart = '0;
  logic [ADDR_W-1:0] curEnd = '0;
  bit expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  zol_sequencer i_zol_sequencer (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .regWrData(regWrData), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .redirectValid(redirectValid), .redirectTarget(redirectTarget),
    .loopActive(loopActive), .repeatCount(repeatCount)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at posedge+1, returns at next posedge+1
  task automatic writeReg(input logic [1:0] sel, input logic [ADDR_W-1:0] data);
    regWrEn = 1'b1; regWrSel = sel; regWrData = data;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  // monitor: scoreboard comparison for every end-address fetch
  always @(negedge clk) begin
    if (armed && fetchValid && fetchAddr == curEnd) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R7 unexpected extra pass", 1, 0);
      end else begin
        bit expRedir;
        expRedir = expQ.pop_front();
        check(redirectValid == expRedir, expRedir ? "R5 redirect" : "R6 final no redirect",
              redirectValid, expRedir);
        if (expRedir)
          check(redirectTarget == curStart, "R2 R5 target", redirectTarget, curStart);
      end
    end
  end

  task automatic runLoop(input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] e,
                         input int n, input bit useImm);
    int expPasses;
    int passes;
    int steps;
    bit redir;
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] nextPc;
    writeReg(2'd0, s);
    writeReg(2'd1, e);
    writeReg(useImm ? 2'd2 : 2'd3, ADDR_W'(n));
    expPasses = (n <= 1) ? 1 : n;
    for (int p = 1; p <= expPasses; p++) expQ.push_back(p < expPasses);
    curStart = s; curEnd = e; armed = 1'b1;
    pc = s; passes = 0; steps = 0;
    forever begin
      fetchValid = 1'b1; fetchAddr = pc;
      @(negedge clk);
      redir = redirectValid;
      nextPc = redir ? redirectTarget : pc + 4;
      if (pc == e) passes++;
      @(posedge clk); #1;
      steps++;
      if ((pc == e && !redir) || steps > 30000) break;
      pc = nextPc;
    end
    fetchValid = 1'b0; armed = 1'b0;
    check(passes == expPasses, useImm ? "R3 R7 pass count" : "R4 R7 pass count", passes, expPasses);
    check(expQ.size() == 0, "R7 scoreboard drained", expQ.size(), 0);
    expQ.delete();
    check(repeatCount == 0, "R6 count zero after loop", repeatCount, 0);
    check(loopActive == 1'b0, "R6 inactive after loop", loopActive, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0;
    // R1 reset state
    check(repeatCount == 0, "R1 count reset", repeatCount, 0);
    check(loopActive == 1'b0, "R1 active reset", loopActive, 0);
    check(redirectTarget == 0, "R1 start reset", redirectTarget, 0);

    // R3 immediate zero-extension
    writeReg(2'd2, 32'h0000_03C5);
    check(repeatCount == 12'h0C5, "R3 imm zero-extend", repeatCount, 12'h0C5);
    check(loopActive == 1'b1, "R3 arms", loopActive, 1);
    // R4 register source keeps 12 bits
    writeReg(2'd3, 32'h0000_1ABC);
    check(repeatCount == 12'hABC, "R4 reg load", repeatCount, 12'hABC);
    rst = 1'b1; @(posedge clk); #1; rst = 1'b0;
    check(loopActive == 1'b0 && repeatCount == 0, "R1 reset mid-loop", repeatCount, 0);

    runLoop(32'h100, 32'h10C, 1, 1'b1);
    runLoop(32'h200, 32'h208, 2, 1'b1);
    runLoop(32'h100, 32'h10C, 0, 1'b1);
    runLoop(32'h300, 32'h30C, 255, 1'b1);
    runLoop(32'h400, 32'h404, 256, 1'b0);
    runLoop(32'h500, 32'h50C, 4095, 1'b0);

    // R8 end fetch while inactive
    fetchValid = 1'b1; fetchAddr = 32'h50C;
    @(negedge clk);
    check(redirectValid == 1'b0, "R8 no redirect idle", redirectValid, 0);
    @(posedge clk); #1;
    fetchValid = 1'b0;
    check(repeatCount == 0 && !loopActive, "R8 state unchanged", repeatCount, 0);

    // R10 invalid fetch at end address while active
    writeReg(2'd3, 32'd3);
    fetchValid = 1'b0; fetchAddr = 32'h50C;
    @(negedge clk);
    check(redirectValid == 1'b0, "R10 no redirect invalid", redirectValid, 0);
    @(posedge clk); #1;
    check(repeatCount == 3 && loopActive, "R10 count held", repeatCount, 3);

    // R9 write collides with end fetch
    fetchValid = 1'b1; fetchAddr = 32'h50C;
    regWrEn = 1'b1; regWrSel = 2'd2; regWrData = 32'd7;
    @(negedge clk);
    check(redirectValid == 1'b0, "R9 write blocks redirect", redirectValid, 0);
    @(posedge clk); #1;
    regWrEn = 1'b0;
    check(repeatCount == 7, "R9 write decides count", repeatCount, 7);
    // R5 single decrement with an isolated end fetch
    @(negedge clk);
    check(redirectValid == 1'b1, "R5 redirect isolated", redirectValid, 1);
    @(posedge clk); #1;
    fetchValid = 1'b0;
    check(repeatCount == 6, "R5 decrement", repeatCount, 6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule